// File: doc/BRIEF.md
# Layer Alpha Compositing Unit

This block composites one display layer pixel over a background pixel. Each pixel is 24 bits: three 8-bit colour channels. The layer pixel arrives with its own alpha, which is 1, 2 or 8 bits wide. A narrow alpha is widened to 8 bits by looking it up in a programmable register that holds four 8-bit alpha levels. A control word selects how the two pixels are merged:

- background only, when the layer is off;
- layer only, when the layer is opaque;
- blending with one constant alpha for the whole plane;
- blending with the alpha of each pixel, either straight or premultiplied.

Plane alpha and pixel alpha are separate modes. They are never multiplied together.

Pixels travel on a valid/ready stream through a two-stage pipeline. Back-pressure from the output stops the whole pipeline. A simple write port loads the control word and the alpha table. The blend kind is decoded once per pixel into one of four named kinds:

- `BK_DST`: the layer is disabled.
- `BK_SRC`: the layer is enabled and opaque.
- `BK_MIX`: plane or pixel blending.
- `BK_PREMUL`: premultiplied pixel blending.

The kind is picked from the control word when the pixel is accepted. It moves down the pipeline with its data.

Top module: `alc_layer_blend`

## Requirements
- R1: After reset, the control word is all zero, so the layer is disabled. The alpha table holds 0xFFAA5500, giving entries 0..3 = 0x00, 0x55, 0xAA, 0xFF. `out_valid` is low and `in_ready` is high.
- R2: A write with `cfg_we`=1 goes to the control word when `cfg_sel`=0 and to the alpha table when `cfg_sel`=1. Entry i of the table is bits [8i+7:8i]. Pixels accepted after the write's clock edge use the new value.
- R3: `in_awidth` 1 means a 1-bit alpha in `in_alpha` bit 0: value 0 selects table entry 0 and value 1 selects entry 3. `in_awidth` 2 means a 2-bit alpha in `in_alpha` bits 1:0, used directly as the table index. `in_awidth` 0 or 3 means the 8-bit `in_alpha` is used as is.
- R4: When control bit 0 (layer enable) is 0, the output equals `in_dst`.
- R5: When the layer is enabled and the mode field (control bits 13:12) is 0 or 1, the output equals `in_src`.
- R6: Mode 2 is plane blending. It uses a = control bits 23:16. Each channel is out = (src·a + dst·(255−a) + 127)/255. The pixel alpha, its width and the premultiply bit have no effect.
- R7: Mode 3 with control bit 14 (premultiply) clear blends each channel with the expanded pixel alpha, using the formula of R6.
- R8: Mode 3 with control bit 14 set gives out = src + (dst·(255−a) + 127)/255 per channel, saturated to 255.
- R9: The pipeline has two stages. A pixel presented in the cycle before rising edge n, and accepted there, is on the output in the cycle after edge n+1, as long as `out_ready` is high. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pix` does not change.
- R10: Under any `out_ready` pattern, every accepted pixel comes out exactly once and in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: control word, 1: alpha table |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_awidth | input | 2 | Alpha width code (see R3) |
| in_alpha | input | 8 | Layer pixel alpha |
| in_src | input | 24 | Layer pixel colour |
| in_dst | input | 24 | Background pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | 24 | Composited pixel |

## Verification
The hold assertion of R9 assumes the handshake is the usual valid/ready one, where the consumer may drop `out_ready` at any time. The lane range checks assume the alpha table and the plane alpha are plain byte values with no extra meaning. The bench drives inputs and `out_ready` only on falling clock edges, so each value is stable across a full rising edge. It exercises every alpha width under every mode. Between its back-pressure bursts it toggles `out_ready` with a pseudo-random sequence, while the R10 scoreboard keeps track of the expected order. Register writes never overlap a pixel handshake in the same cycle, so the register value each pixel sees is unambiguous.

// File: rtl/alc_pkg.sv
package alc_pkg;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_MODE_LSB = 12;
    localparam int CTRL_PREMUL_BIT = 14;
    localparam int CTRL_PALPHA_LSB = 16;
    localparam logic [1:0] MODE_PLANE = 2'd2;
    localparam logic [1:0] MODE_PIXEL = 2'd3;
    localparam logic [1:0] AW_ONE = 2'd1;
    localparam logic [1:0] AW_TWO = 2'd2;
    localparam logic [31:0] LUT_RESET = 32'hFFAA5500;

    typedef enum logic [1:0] {
        BK_DST    = 2'd0,
        BK_SRC    = 2'd1,
        BK_MIX    = 2'd2,
        BK_PREMUL = 2'd3
    } blend_kind_e;
endpackage

// File: rtl/alc_cfg_regs.sv
module alc_cfg_regs
    import alc_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             layer_en,
    output logic [1:0]       mode,
    output logic             premul,
    output logic [CH_W-1:0]  plane_alpha,
    output logic [CFG_W-1:0] lut
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            layer_en    <= 1'b0;
            mode        <= 2'd0;
            premul      <= 1'b0;
            plane_alpha <= '0;
            lut         <= LUT_RESET;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                lut <= cfg_wdata;
            end else begin
                layer_en    <= cfg_wdata[CTRL_EN_BIT];
                mode        <= cfg_wdata[CTRL_MODE_LSB +: 2];
                premul      <= cfg_wdata[CTRL_PREMUL_BIT];
                plane_alpha <= cfg_wdata[CTRL_PALPHA_LSB +: CH_W];
            end
        end
    end

    // R2: a table write lands in the table one edge later
    a_r2_lut_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (lut == $past(cfg_wdata)));
endmodule

// File: rtl/alc_alpha_expand.sv
module alc_alpha_expand
    import alc_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [1:0]        awidth,
    input  logic [CH_W-1:0]   alpha_raw,
    input  logic [4*CH_W-1:0] lut,
    output logic [CH_W-1:0]   alpha_full
);
    logic [1:0] idx;

    always_comb begin
        idx = (awidth == AW_ONE) ? {2{alpha_raw[0]}} : alpha_raw[1:0];
        if (awidth == AW_ONE || awidth == AW_TWO) begin
            alpha_full = lut[idx*CH_W +: CH_W];
        end else begin
            alpha_full = alpha_raw;
        end
    end
endmodule

// File: rtl/alc_blend_lane.sv
module alc_blend_lane
    import alc_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  blend_kind_e     kind,
    input  logic [CH_W-1:0] alpha,
    input  logic [CH_W-1:0] src,
    input  logic [CH_W-1:0] dst,
    output logic [CH_W-1:0] pix
);
    localparam int PW = 2*CH_W + 2;
    localparam logic [PW-1:0] MAXV = PW'((1 << CH_W) - 1);
    localparam logic [PW-1:0] HALF = MAXV >> 1;

    logic [PW-1:0] inv_a, dst_part, mix_q, sum;

    always_comb begin
        inv_a    = MAXV - PW'(alpha);
        dst_part = PW'(dst) * inv_a;
        mix_q    = (PW'(src) * PW'(alpha) + dst_part + HALF) / MAXV;
        sum      = PW'(src) + (dst_part + HALF) / MAXV;
        unique case (kind)
            BK_DST:    pix = dst;
            BK_SRC:    pix = src;
            BK_MIX:    pix = (mix_q > MAXV) ? MAXV[CH_W-1:0] : mix_q[CH_W-1:0];
            BK_PREMUL: pix = (sum > MAXV) ? MAXV[CH_W-1:0] : sum[CH_W-1:0];
        endcase
    end

    // R7: a straight blend lies between its two inputs
    always_comb begin
        if (kind == BK_MIX) begin
            a_r7_mix_range: assert ((pix >= src && pix <= dst) || (pix >= dst && pix <= src));
        end
    end

    // R8: premultiplied output never drops below the layer colour
    always_comb begin
        if (kind == BK_PREMUL) begin
            a_r8_premul_floor: assert (pix >= src);
        end
    end
endmodule

// File: rtl/alc_layer_blend.sv
module alc_layer_blend
    import alc_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int N_CH = 3,
    parameter int CFG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_awidth,
    input  logic [CH_W-1:0]      in_alpha,
    input  logic [N_CH*CH_W-1:0] in_src,
    input  logic [N_CH*CH_W-1:0] in_dst,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [N_CH*CH_W-1:0] out_pix
);
    localparam int PIX_W = N_CH * CH_W;

    logic             layer_en, premul;
    logic [1:0]       mode;
    logic [CH_W-1:0]  plane_alpha, pix_alpha;
    logic [CFG_W-1:0] lut;

    blend_kind_e     kind_d, s1_kind;
    logic [CH_W-1:0] alpha_d, s1_alpha;
    logic [PIX_W-1:0] s1_src, s1_dst, lane_pix;
    logic            s1_valid, s2_valid, advance, accept;

    alc_cfg_regs #(.CH_W(CH_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .layer_en(layer_en), .mode(mode),
        .premul(premul), .plane_alpha(plane_alpha), .lut(lut)
    );

    alc_alpha_expand #(.CH_W(CH_W)) u_exp (
        .awidth(in_awidth), .alpha_raw(in_alpha),
        .lut(lut[4*CH_W-1:0]), .alpha_full(pix_alpha)
    );

    // blend-kind decode
    always_comb begin
        alpha_d = pix_alpha;
        if (!layer_en) begin
            kind_d = BK_DST;
        end else begin
            unique case (mode)
                MODE_PLANE: begin
                    kind_d  = BK_MIX;
                    alpha_d = plane_alpha;
                end
                MODE_PIXEL: kind_d = premul ? BK_PREMUL : BK_MIX;
                default:    kind_d = BK_SRC;
            endcase
        end
    end

    assign advance  = !s2_valid || out_ready;
    assign in_ready = advance;
    assign accept   = in_valid && advance;

    // stage 1: decoded kind, alpha and operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_kind  <= BK_DST;
            s1_alpha <= '0;
            s1_src   <= '0;
            s1_dst   <= '0;
        end else if (advance) begin
            s1_valid <= accept;
            if (accept) begin
                s1_kind  <= kind_d;
                s1_alpha <= alpha_d;
                s1_src   <= in_src;
                s1_dst   <= in_dst;
            end
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        alc_blend_lane #(.CH_W(CH_W)) u_lane (
            .kind(s1_kind), .alpha(s1_alpha),
            .src(s1_src[c*CH_W +: CH_W]), .dst(s1_dst[c*CH_W +: CH_W]),
            .pix(lane_pix[c*CH_W +: CH_W])
        );
    end

    // stage 2: composited result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            out_pix  <= '0;
        end else if (advance) begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                out_pix <= lane_pix;
            end
        end
    end

    assign out_valid = s2_valid;

    a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: nothing enters stage 2 while it is stalled
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && s1_valid) |=> (s1_valid && out_valid));
endmodule

// File: tb/sim_alc_layer_blend.sv
module sim_alc_layer_blend;
    localparam int PERIOD = 10;

    typedef struct {
        logic [23:0] pix;
        string       req;
        int          due;
        bit          lat;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1;
    logic [1:0] in_awidth = 0;
    logic [7:0] in_alpha = 0;
    logic [23:0] in_src = 0, in_dst = 0, out_pix;

    int checks = 0, errors = 0, cyc = 0;
    exp_t sb[$];
    logic [31:0] sh_ctrl = 0, sh_lut = 32'hFFAA5500;
    bit stall_mode = 0, done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alc_layer_blend u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_awidth(in_awidth), .in_alpha(in_alpha), .in_src(in_src),
        .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input logic [1:0] aw, input logic [7:0] a,
                                          input logic [23:0] s, input logic [23:0] d);
        logic [7:0] ea, oc;
        int sc, dc, v;
        logic [23:0] r;
        if (aw == 2'd1) ea = a[0] ? sh_lut[31:24] : sh_lut[7:0];
        else if (aw == 2'd2) ea = sh_lut[a[1:0]*8 +: 8];
        else ea = a;
        if (sh_ctrl[13:12] == 2'd2) ea = sh_ctrl[23:16];
        for (int c = 0; c < 3; c++) begin
            sc = int'(s[c*8 +: 8]);
            dc = int'(d[c*8 +: 8]);
            if (!sh_ctrl[0]) v = dc;
            else if (sh_ctrl[13:12] < 2) v = sc;
            else if (sh_ctrl[13:12] == 3 && sh_ctrl[14]) begin
                v = sc + (dc * (255 - int'(ea)) + 127) / 255;
                if (v > 255) v = 255;
            end else v = (sc * int'(ea) + dc * (255 - int'(ea)) + 127) / 255;
            oc = 8'(v);
            r[c*8 +: 8] = oc;
        end
        return r;
    endfunction

    task automatic cfg_write(input bit sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
        if (sel) sh_lut = val; else sh_ctrl = val;
    endtask

    task automatic send(input logic [1:0] aw, input logic [7:0] a, input logic [23:0] s,
                        input logic [23:0] d, input string req, input bit lat);
        exp_t e;
        bit got = 0;
        @(negedge clk);
        in_valid = 1; in_awidth = aw; in_alpha = a; in_src = s; in_dst = d;
        while (!got) begin
            #2;
            if (in_ready) begin
                e.pix = model(aw, a, s, d);
                e.req = req;
                e.due = cyc + 2;
                e.lat = lat;
                sb.push_back(e);
                got = 1;
            end
            @(posedge clk);
            if (!got) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
        check(sb.size() == 0, "R10 drain", 32'(sb.size()), 0);
    endtask

    // monitor / scoreboard
    initial begin
        bit prev_stall = 0;
        logic [23:0] prev_pix = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_mode ? lfsr[0] : 1'b1;
            #2;
            if (prev_stall && rst_n)
                check(out_valid && out_pix == prev_pix, "R9 hold", {7'd0, out_valid, out_pix}, {8'd1, prev_pix});
            if (out_valid && !out_ready && rst_n)
                check(!in_ready, "R9 ready low", 32'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (sb.size() == 0) check(0, "R10 extra output", 32'(out_pix), 0);
                else begin
                    e = sb.pop_front();
                    check(out_pix == e.pix, e.req, 32'(out_pix), 32'(e.pix));
                    if (e.lat) check(cyc == e.due, "R9 latency", cyc, e.due);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_pix = out_pix;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 3 + 1);
        check(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
        check(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
        rst_n = 1;
        // R1 / R4: default control disables the layer
        send(2'd0, 8'hFF, 24'h112233, 24'hA0B0C0, "R1 R4 disabled default", 1);
        send(2'd0, 8'h00, 24'hFFFFFF, 24'h010203, "R4 disabled", 1);
        drain();
        // R5: enabled, opaque modes 0 and 1
        cfg_write(0, 32'h0000_0001);
        send(2'd0, 8'h10, 24'h445566, 24'h000000, "R5 mode0", 1);
        cfg_write(0, 32'h0000_1001);
        send(2'd2, 8'h01, 24'h778899, 24'hFFFFFF, "R5 mode1", 1);
        // R6: plane alpha, pixel alpha and premultiply ignored
        cfg_write(0, 32'h0080_6001);
        send(2'd0, 8'hFF, 24'hFF0080, 24'h00FF40, "R6 plane a=80", 1);
        send(2'd1, 8'h01, 24'hFF0080, 24'h00FF40, "R6 plane ignores 1b alpha", 1);
        send(2'd2, 8'h00, 24'h102030, 24'hF0E0D0, "R6 plane ignores 2b alpha", 1);
        cfg_write(0, 32'h0000_2001);
        send(2'd0, 8'hFF, 24'h123456, 24'h9ABCDE, "R6 plane a=0", 1);
        // R7: pixel alpha, straight
        cfg_write(0, 32'h0000_3001);
        send(2'd0, 8'h00, 24'h123456, 24'h9ABCDE, "R7 a=00", 1);
        send(2'd0, 8'hFF, 24'h123456, 24'h9ABCDE, "R7 a=FF", 1);
        send(2'd0, 8'h40, 24'hC8641E, 24'h1E64C8, "R7 a=40", 1);
        // R3: narrow alpha through default table
        send(2'd1, 8'h00, 24'hFFFFFF, 24'h000000, "R3 1b zero", 1);
        send(2'd1, 8'hFF, 24'hFFFFFF, 24'h000000, "R3 1b one", 1);
        for (int i = 0; i < 4; i++)
            send(2'd2, 8'(i), 24'hFFFFFF, 24'h000000, "R3 2b default", 1);
        send(2'd3, 8'h80, 24'hFFFFFF, 24'h000000, "R3 code3 8b", 1);
        drain();
        // R2: custom table
        cfg_write(1, 32'h10_C0_30_08);
        for (int i = 0; i < 4; i++)
            send(2'd2, 8'(i), 24'hFF8000, 24'h0080FF, "R2 R3 custom table", 1);
        send(2'd1, 8'h01, 24'hFF8000, 24'h0080FF, "R2 R3 1b custom", 1);
        // R8: premultiplied
        cfg_write(0, 32'h0000_7001);
        send(2'd0, 8'h80, 24'h402010, 24'h804020, "R8 premul", 1);
        send(2'd0, 8'h00, 24'hFFF0C0, 24'hFF2080, "R8 saturate", 1);
        send(2'd0, 8'hFF, 24'h102030, 24'hFFFFFF, "R8 a=FF", 1);
        drain();
        // R10: back-pressure with mixed modes
        stall_mode = 1;
        cfg_write(0, 32'h0000_3001);
        for (int i = 0; i < 40; i++)
            send(2'(i % 3), 8'(i * 37), 24'(i * 24'h050B13), 24'(24'hFFFFFF - i * 24'h030507), "R10 stream", 0);
        drain();
        stall_mode = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule